// File: doc/BRIEF.md
# Comparator Timer Channel with Counter-Wrap Interrupt

This block is one compare channel of a high-resolution event timer. A shared main counter outside the block drives `cnt_val` and marks each new value with `cnt_step`. The channel holds a comparator and a period. When the counter catches up with the comparator, the channel issues a one-cycle interrupt pulse.

In one-shot mode the channel fires once for each time it is armed. In periodic mode it adds the period to the comparator after every hit. If the counter has already run past several periods, the channel steps the comparator forward until it is ahead again, so the missed periods never fire. A 32-bit mode limits the comparison and the reload arithmetic to the low word. In the one-shot form of that mode, the channel also fires when the counter's low word rolls over before the match is reached.

Software-style register writes arrive as 32-bit strobes on three targets: the config word, the comparator low word and the comparator high word. A steering bit in the config word decides whether a comparator write lands in the comparator or in the period.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the hidden period is zero, `irq` is 0, and `cfg_rd` reads 0x30. Nothing fires until a comparator word is written or the global enable rises while the comparator is not all ones.
- R2: Config bit positions are: bit 1 level request, bit 2 channel enable, bit 3 periodic, bit 4 periodic-capable, bit 5 wide-capable, bit 6 steer-to-comparator (SETVAL), bit 8 32-bit mode. All other bits read 0. A written bit 1 is ignored and always reads 0. Bits 4 and 5 always read 1.
- R3: In one-shot mode, after a comparator write, `irq` is high for one cycle. This happens one clock after the first counter step whose value is not ahead of the comparator. "Not ahead" means the signed difference comparator minus counter is not positive. The channel then stays silent until it is re-armed.
- R4: A pulse appears only when both the channel enable (bit 2) and `glb_en` are 1.
- R5: In periodic mode with a nonzero period, the pulses fall at the comparator value and then at every further period.
- R6: When one step carries the counter past several periods, exactly one pulse is emitted. The comparator then advances by whole periods to the first value ahead of the counter.
- R7: In 32-bit mode only the low words are compared, with a 32-bit signed difference. A config write with bit 8 set clears the high words of the comparator and the period. Periodic reloads wrap modulo 2^32.
- R8: In one-shot 32-bit mode, if the counter's low word will roll over before the match, a pulse is emitted at the step where the low word wraps to a smaller value. The match pulse still follows later.
- R9: A comparator-low write loads the comparator low word when the channel is one-shot or SETVAL is 1. In periodic mode it also loads the period low word.
- R10: A comparator-high write loads the comparator high word when the channel is one-shot or SETVAL is 1. Otherwise it loads the period high word.
- R11: A value written into the period has its top bit cleared. This is bit 31 of a low-word write in 32-bit mode and bit 63 on a high-word write.
- R12: SETVAL returns to 0 after any comparator-low or comparator-high write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 2*WORD_W | Main counter value |
| cnt_step | input | 1 | High when `cnt_val` carries a new counter value |
| glb_en | input | 1 | Global timer enable |
| wr_cfg | input | 1 | Write strobe for the config word |
| wr_cmp_lo | input | 1 | Write strobe for the comparator low word |
| wr_cmp_hi | input | 1 | Write strobe for the comparator high word |
| wdata | input | WORD_W | Write data |
| cfg_rd | output | WORD_W | Config word readback |
| cmp_rd | output | 2*WORD_W | Comparator readback |
| irq | output | 1 | Registered one-cycle interrupt pulse |

## Verification
The bench builds the block with the default WORD_W of 32, which gives a 64-bit counter. Because the bench drives the counter directly, it can place the counter just below 2^32 and cross the 32-bit rollover within a few dozen cycles. It can also jump the counter by several periods in a single step, and load period values whose top bits reach bit 63. A seeded random run of register writes, with the timer globally stopped, is compared against a bench model of the write steering. Directed runs then check the pulse timing against counter values computed by hand.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  // Config word bit positions
  localparam int CB_LVL  = 1;
  localparam int CB_EN   = 2;
  localparam int CB_PER  = 3;
  localparam int CB_PCAP = 4;
  localparam int CB_WCAP = 5;
  localparam int CB_SETV = 6;
  localparam int CB_M32  = 8;
endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
  import evt_chan_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              d_en,
  input  logic              d_per,
  input  logic              d_setv,
  input  logic              d_m32,
  input  logic              clr_setv,
  output logic              en,
  output logic              periodic,
  output logic              setval,
  output logic              m32,
  output logic [WORD_W-1:0] cfg_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      periodic <= 1'b0;
      setval   <= 1'b0;
      m32      <= 1'b0;
    end else if (wr_cfg) begin
      en       <= d_en;
      periodic <= d_per;
      setval   <= d_setv;
      m32      <= d_m32;
    end else if (clr_setv) begin
      setval <= 1'b0;
    end
  end

  // Level request is never stored; capability bits are constant
  always_comb begin
    cfg_word          = '0;
    cfg_word[CB_EN]   = en;
    cfg_word[CB_PER]  = periodic;
    cfg_word[CB_PCAP] = 1'b1;
    cfg_word[CB_WCAP] = 1'b1;
    cfg_word[CB_SETV] = setval;
    cfg_word[CB_M32]  = m32;
  end
endmodule

// File: rtl/evt_chan_store.sv
module evt_chan_store #(
  parameter  int WORD_W = 32,
  localparam int CNT_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              periodic,
  input  logic              setval,
  input  logic              m32,
  input  logic              wr_cfg,
  input  logic              cfg_m32_in,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              add_req,
  output logic [CNT_W-1:0]  cmp,
  output logic [CNT_W-1:0]  period
);
  logic              to_cmp;
  logic [WORD_W-1:0] wd_top_clr;
  logic [WORD_W-1:0] per_lo_val;
  logic [CNT_W-1:0]  sum_raw;
  logic [CNT_W-1:0]  sum;

  assign to_cmp     = !periodic || setval;
  assign wd_top_clr = {1'b0, wdata[WORD_W-2:0]};
  assign per_lo_val = m32 ? wd_top_clr : wdata;
  assign sum_raw    = cmp + period;

  generate
    if (CNT_W > WORD_W) begin : g_wrap_sum
      assign sum = m32 ? {{(CNT_W-WORD_W){1'b0}}, sum_raw[WORD_W-1:0]} : sum_raw;
    end else begin : g_plain_sum
      assign sum = sum_raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp    <= '1;
      period <= '0;
    end else if (wr_cfg) begin
      if (cfg_m32_in) begin
        cmp[CNT_W-1:WORD_W]    <= '0;
        period[CNT_W-1:WORD_W] <= '0;
      end
    end else if (wr_lo) begin
      if (to_cmp) cmp[WORD_W-1:0] <= wdata;
      if (periodic) period[WORD_W-1:0] <= per_lo_val;
    end else if (wr_hi) begin
      if (to_cmp) cmp[CNT_W-1:WORD_W] <= wdata;
      else        period[CNT_W-1:WORD_W] <= wd_top_clr;
    end else if (add_req) begin
      cmp <= sum;
    end
  end
endmodule

// File: rtl/evt_chan_match.sv
module evt_chan_match #(
  parameter  int WORD_W = 32,
  localparam int CNT_W  = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             periodic,
  input  logic             m32,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_step,
  input  logic             glb_en,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] period,
  input  logic             arm_evt,
  output logic             add_req,
  output logic             irq
);
  logic                     arm_req, armed, catching, wrap_pend, glb_q;
  logic [WORD_W-1:0]        prev_lo;
  logic signed [CNT_W-1:0]  d_full;
  logic signed [WORD_W-1:0] d_low;
  logic [WORD_W-1:0]        wrap_head;
  logic ahead, wrap_seen, period_nz, eval, hit_match, hit_wrap, reload;
  logic pend_new, glb_rise;

  assign d_full    = cmp - cnt_val;
  assign d_low     = cmp[WORD_W-1:0] - cnt_val[WORD_W-1:0];
  assign ahead     = m32 ? (d_low > 0) : (d_full > 0);
  assign wrap_seen = cnt_step && (cnt_val[WORD_W-1:0] < prev_lo);
  assign period_nz = m32 ? (|period[WORD_W-1:0]) : (|period);
  assign eval      = glb_en && armed && cnt_step && !catching && !arm_req;
  assign hit_match = eval && !ahead;
  assign hit_wrap  = eval && wrap_pend && wrap_seen;
  assign reload    = hit_match && periodic && period_nz;
  assign add_req   = reload || (catching && !ahead && !arm_req);
  assign wrap_head = '1 - cnt_val[WORD_W-1:0];
  assign pend_new  = m32 && !periodic && (d_low > 0) &&
                     (wrap_head < $unsigned(d_low));
  assign glb_rise  = glb_en && !glb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_req   <= 1'b0;
      armed     <= 1'b0;
      catching  <= 1'b0;
      wrap_pend <= 1'b0;
      glb_q     <= 1'b0;
      prev_lo   <= '0;
      irq       <= 1'b0;
    end else begin
      glb_q <= glb_en;
      if (cnt_step) prev_lo <= cnt_val[WORD_W-1:0];
      irq     <= (hit_match || hit_wrap) && en;
      arm_req <= arm_evt || (glb_rise && !(&cmp));
      if (arm_req) begin
        armed     <= 1'b1;
        wrap_pend <= pend_new;
        catching  <= 1'b0;
      end else begin
        if (hit_match && !reload) begin
          armed     <= 1'b0;
          wrap_pend <= 1'b0;
        end else if (hit_wrap) begin
          wrap_pend <= 1'b0;
        end
        if (reload) catching <= 1'b1;
        else if (catching && ahead) catching <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_chan_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int CNT_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_step,
  input  logic              glb_en,
  input  logic              wr_cfg,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cfg_rd,
  output logic [CNT_W-1:0]  cmp_rd,
  output logic              irq
);
  logic en, periodic, setval, m32, add_req;
  logic [CNT_W-1:0] period;

  evt_chan_cfg #(.WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg),
    .d_en(wdata[CB_EN]), .d_per(wdata[CB_PER]),
    .d_setv(wdata[CB_SETV]), .d_m32(wdata[CB_M32]),
    .clr_setv(wr_cmp_lo || wr_cmp_hi),
    .en(en), .periodic(periodic), .setval(setval), .m32(m32),
    .cfg_word(cfg_rd)
  );

  evt_chan_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .periodic(periodic), .setval(setval), .m32(m32),
    .wr_cfg(wr_cfg), .cfg_m32_in(wdata[CB_M32]),
    .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wdata(wdata),
    .add_req(add_req), .cmp(cmp_rd), .period(period)
  );

  evt_chan_match #(.WORD_W(WORD_W)) u_match (
    .clk(clk), .rst(rst), .en(en), .periodic(periodic), .m32(m32),
    .cnt_val(cnt_val), .cnt_step(cnt_step), .glb_en(glb_en),
    .cmp(cmp_rd), .period(period), .arm_evt(wr_cmp_lo || wr_cmp_hi),
    .add_req(add_req), .irq(irq)
  );
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_en,
  input logic              wr_cfg,
  input logic              wr_cmp,
  input logic              wd_m32,
  input logic              rd_lvl,
  input logic              rd_en,
  input logic [1:0]        rd_caps,
  input logic              rd_setv,
  input logic [WORD_W-1:0] cmp_hi,
  input logic              irq
);
  // R4: a pulse needs both enables in the cycle that produced it
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(glb_en) && $past(rd_en)));

  // R2: level request never sticks, capability bits stay set
  assert_level_zero_R2: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> (!rd_lvl && rd_caps == 2'b11));

  // R12: steering bit falls after a comparator word write
  assert_setval_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_cmp && !wr_cfg) |=> !rd_setv);

  // R7: entering 32-bit mode clears the comparator high word
  assert_trunc_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && wd_m32) |=> (cmp_hi == '0));
endmodule

bind evt_cmp_channel evt_chan_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .wr_cfg(wr_cfg),
  .wr_cmp(wr_cmp_lo || wr_cmp_hi), .wd_m32(wdata[8]),
  .rd_lvl(cfg_rd[1]), .rd_en(cfg_rd[2]), .rd_caps(cfg_rd[5:4]),
  .rd_setv(cfg_rd[6]), .cmp_hi(cmp_rd[2*WORD_W-1:WORD_W]), .irq(irq)
);

// File: tb/test_evt_cmp_channel.sv
`timescale 1ns/1ps
module test_evt_cmp_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt_val = '0;
  logic        cnt_step = 1'b0;
  logic        glb_en = 1'b0;
  logic        wr_cfg = 1'b0, wr_cmp_lo = 1'b0, wr_cmp_hi = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] cfg_rd;
  logic [63:0] cmp_rd;
  logic        irq;

  int n_tests = 0, n_fail = 0, cyc = 0, n_irq = 0;
  bit done = 0;
  logic [63:0] nxt = '0, shown = '0;
  logic [63:0] irq_v [4];

  evt_cmp_channel i_evt_cmp_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_step(cnt_step),
    .glb_en(glb_en), .wr_cfg(wr_cfg), .wr_cmp_lo(wr_cmp_lo),
    .wr_cmp_hi(wr_cmp_hi), .wdata(wdata), .cfg_rd(cfg_rd),
    .cmp_rd(cmp_rd), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements) act=%0d exp=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic log_irq();
    if (irq) begin
      if (n_irq < 4) irq_v[n_irq] = shown;
      n_irq++;
    end
  endtask

  task automatic clear_log();
    n_irq = 0;
    for (int i = 0; i < 4; i++) irq_v[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clear_log();
  endtask

  // kind: 0 config, 1 comparator low, 2 comparator high
  task automatic wr(input int kind, input logic [31:0] d);
    @(negedge clk);
    log_irq();
    wdata = d;
    wr_cfg = (kind == 0); wr_cmp_lo = (kind == 1); wr_cmp_hi = (kind == 2);
    @(negedge clk);
    log_irq();
    wr_cfg = 1'b0; wr_cmp_lo = 1'b0; wr_cmp_hi = 1'b0;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    @(negedge clk);
    log_irq();
    cnt_val = v; cnt_step = 1'b1; shown = v;
    @(negedge clk);
    log_irq();
    cnt_step = 1'b0;
    nxt = v + 64'd1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      log_irq();
      cnt_val = nxt; cnt_step = 1'b1; shown = nxt; nxt = nxt + 64'd1;
    end
    @(negedge clk);
    log_irq();
    cnt_step = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      log_irq();
    end
  endtask

  // periodic setup: comparator = c, period = p, with config word cw
  task automatic set_periodic(input logic [31:0] cw, input logic [31:0] c, input logic [31:0] p);
    wr(0, cw | 32'h48);
    wr(2, 32'h0);
    wr(0, cw | 32'h48);
    wr(1, c);
    wr(1, p);
  endtask

  // bench model of register steering
  bit m_en, m_per, m_setv, m_m32;
  logic [63:0] m_cmp, m_prd;

  function automatic logic [31:0] model_cfg();
    return (32'(m_m32) << 8) | (32'(m_setv) << 6) | 32'h30 |
           (32'(m_per) << 3) | (32'(m_en) << 2);
  endfunction

  task automatic model_write(input int kind, input logic [31:0] d);
    if (kind == 0) begin
      m_en = d[2]; m_per = d[3]; m_setv = d[6]; m_m32 = d[8];
      if (d[8]) begin m_cmp[63:32] = '0; m_prd[63:32] = '0; end
    end else if (kind == 1) begin
      if (!m_per || m_setv) m_cmp[31:0] = d;
      if (m_per) m_prd[31:0] = m_m32 ? {1'b0, d[30:0]} : d;
      m_setv = 0;
    end else begin
      if (!m_per || m_setv) m_cmp[63:32] = d;
      else m_prd[63:32] = {1'b0, d[30:0]};
      m_setv = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    check(cfg_rd == 32'h30, "R1 cfg_rd after reset", 64'(cfg_rd), 64'h30);
    check(cmp_rd == '1, "R1 cmp_rd after reset", cmp_rd, '1);
    check(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);

    // Random register steering with the timer stopped (R2 R9 R10 R12)
    m_en = 0; m_per = 0; m_setv = 0; m_m32 = 0; m_cmp = '1; m_prd = '0;
    for (int k = 0; k < 60; k++) begin
      int kind;
      logic [31:0] d;
      kind = int'($urandom % 3);
      d = $urandom;
      wr(kind, d);
      model_write(kind, d);
      check(cfg_rd == model_cfg(), "R2/R12 cfg_rd random", 64'(cfg_rd), 64'(model_cfg()));
      check(cmp_rd == m_cmp, "R9/R10 cmp_rd random", cmp_rd, m_cmp);
    end

    // R2 directed: level request ignored
    wr(0, 32'h2);
    check(cfg_rd == 32'h30, "R2 level bit ignored", 64'(cfg_rd), 64'h30);
    check(n_irq == 0, "R4 no pulse with glb_en low", 64'(n_irq), 64'h0);

    // R3 one-shot 64-bit match
    glb_en = 1'b1;
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h4); wr(2, 32'h0); wr(1, 32'd50);
    run(80);
    check(n_irq == 1, "R3 one-shot pulse count", 64'(n_irq), 64'd1);
    check(irq_v[0] == 64'd50, "R3 one-shot pulse position", irq_v[0], 64'd50);

    // R4 channel enable off
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h0); wr(2, 32'h0); wr(1, 32'd30);
    run(50);
    check(n_irq == 0, "R4 channel disabled", 64'(n_irq), 64'd0);

    // R4 global enable off
    glb_en = 1'b0;
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h4); wr(2, 32'h0); wr(1, 32'd30);
    run(50);
    check(n_irq == 0, "R4 global disabled", 64'(n_irq), 64'd0);
    glb_en = 1'b1;

    // R5 periodic
    do_reset();
    set_cnt(64'd0);
    set_periodic(32'h4, 32'd20, 32'd15);
    clear_log();
    run(60);
    check(n_irq == 3, "R5 periodic pulse count", 64'(n_irq), 64'd3);
    check(irq_v[0] == 64'd20, "R5 first periodic pulse", irq_v[0], 64'd20);
    check(irq_v[1] == 64'd35, "R5 second periodic pulse", irq_v[1], 64'd35);
    check(irq_v[2] == 64'd50, "R5 third periodic pulse", irq_v[2], 64'd50);

    // R6 missed periods skipped
    do_reset();
    set_cnt(64'd0);
    set_periodic(32'h4, 32'd100, 32'd10);
    clear_log();
    nxt = 64'd135;
    run(1);
    idle(6);
    check(n_irq == 1, "R6 single pulse on jump", 64'(n_irq), 64'd1);
    check(irq_v[0] == 64'd135, "R6 pulse at jump", irq_v[0], 64'd135);
    check(cmp_rd == 64'd140, "R6 comparator after catch-up", cmp_rd, 64'd140);
    run(10);
    check(n_irq == 2 && irq_v[1] == 64'd140, "R6 next pulse at 140", irq_v[1], 64'd140);

    // R11 period top bit cleared on a 64-bit high write
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h4C); wr(2, 32'h0);
    wr(0, 32'h4C); wr(1, 32'd10);
    wr(1, 32'd5);
    wr(2, 32'hFFFF_FFFF);
    clear_log();
    nxt = 64'd10;
    run(1);
    idle(3);
    check(cmp_rd == 64'h7FFF_FFFF_0000_000F, "R11 64-bit period msb", cmp_rd, 64'h7FFF_FFFF_0000_000F);

    // R7 truncation and modulo reload in 32-bit mode
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h14C);
    check(cmp_rd == 64'h0000_0000_FFFF_FFFF, "R7 truncate on mode write", cmp_rd, 64'h0000_0000_FFFF_FFFF);
    wr(1, 32'hFFFF_FFF8);
    wr(1, 32'h10);
    clear_log();
    nxt = 64'h0000_0000_FFFF_FFF8;
    run(1);
    idle(3);
    check(n_irq == 1, "R7 32-bit periodic pulse", 64'(n_irq), 64'd1);
    check(cmp_rd == 64'h8, "R7 reload wraps mod 2^32", cmp_rd, 64'h8);

    // R11 period top bit cleared on a 32-bit low write
    do_reset();
    set_cnt(64'd0);
    wr(0, 32'h14C); wr(1, 32'd10); wr(1, 32'hFFFF_FFF0);
    clear_log();
    nxt = 64'd10;
    run(1);
    idle(3);
    check(cmp_rd == 64'h7FFF_FFFA, "R11 32-bit period msb", cmp_rd, 64'h7FFF_FFFA);

    // R8 wrap pulse in one-shot 32-bit mode
    do_reset();
    set_cnt(64'h0000_0000_FFFF_FFF0);
    wr(0, 32'h104);
    wr(1, 32'h10);
    clear_log();
    run(40);
    check(n_irq == 2, "R8 wrap plus match count", 64'(n_irq), 64'd2);
    check(irq_v[0] == 64'h1_0000_0000, "R8 wrap pulse", irq_v[0], 64'h1_0000_0000);
    check(irq_v[1] == 64'h1_0000_0010, "R8 match after wrap", irq_v[1], 64'h1_0000_0010);

    // R12 directed: SETVAL clears, second write steers to period only
    do_reset();
    wr(0, 32'h48);
    wr(1, 32'h55);
    check(cfg_rd[6] == 1'b0, "R12 setval cleared", 64'(cfg_rd[6]), 64'h0);
    wr(1, 32'h77);
    check(cmp_rd[31:0] == 32'h55, "R9 periodic low write skips comparator", 64'(cmp_rd[31:0]), 64'h55);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule